// File: doc/BRIEF.md
# Auto-Increment Slave Programming Sequencer

This block walks through a run of consecutive nonvolatile memory words while the device is in slave programming mode. A host gives it one starting word address and a direction: program (write) or dump (read). From then on the block handles one word at a time. It drives a memory access port with an address, write data and a read or write strobe, and it waits for the memory's completion signal before it moves on. No new address has to come from the host between words.

When a word completes, the block looks at an active-low auto-increment input in that same cycle. If the input is low, the block steps the address by one and starts the next word. In program mode it first waits for fresh host data. In dump mode it starts the next read at once. If the input is high, the block goes back to idle, and nothing more happens until the host loads a new address. In dump mode each word read is handed to the host with a data-valid pulse one cycle long.

Top module: `aseq_top`

## Requirements
- R1: While reset is applied and after it, the block is idle: `busy`, `mem_wr`, `mem_rd` and `host_rvalid` are all 0.
- R2: A `host_load` pulse in idle latches `host_addr` as the word address and `host_prog` as the mode (1 = program, 0 = dump), and `busy` rises on the next cycle. A `host_load` that arrives while busy is ignored.
- R3: In program mode no write starts until `host_wvalid` is seen. The word on `host_wdata` in that cycle is captured. `mem_wr` then stays high with the same address and data until `mem_done`, and `host_wvalid` has no effect while the write is in progress.
- R4: In dump mode `mem_rd` stays high at a fixed address until `mem_done`. In the cycle after `mem_done`, `host_rvalid` is 1 for exactly that cycle and `host_rdata` holds the `mem_rdata` value from the done cycle.
- R5: `auto_inc_n` is sampled only in a cycle where an access is in progress and `mem_done` is 1. If it is 0, the address advances by one: a dump goes straight into the next read, and a program waits for the next `host_wvalid`.
- R6: If `auto_inc_n` is 1 when sampled, the block goes back to idle (`busy` = 0, no strobe) and waits for a new `host_load`.
- R7: The word address is 16 bits wide and steps from 0xFFFF to 0x0000.
- R8: `mem_wr` and `mem_rd` are never high together, and neither is high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_load | input | 1 | Starting address and mode valid (pulse) |
| host_addr | input | 16 | Starting word address |
| host_prog | input | 1 | Mode: 1 program, 0 dump |
| host_wvalid | input | 1 | Host write word valid |
| host_wdata | input | 16 | Host write word |
| host_rvalid | output | 1 | One-cycle pulse: dumped word valid |
| host_rdata | output | 16 | Dumped word |
| auto_inc_n | input | 1 | Active-low auto-increment request |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write word |
| mem_wr | output | 1 | Write strobe, held until done |
| mem_rd | output | 1 | Read strobe, held until done |
| mem_rdata | input | 16 | Memory read word |
| mem_done | input | 1 | Memory access complete |
| busy | output | 1 | Sequence active |

## Verification
Every output comes from a register, so each stimulus shows its effect one edge later:
- After a load edge, `busy` and the new `mem_addr` appear, and in dump mode `mem_rd` appears too.
- After the edge on which `host_wvalid` is captured, `mem_wr` and `mem_wdata` appear.
- After a done edge, the `host_rvalid` pulse, the stepped address or the return to idle appears.

The bench keeps a behavioural model of the sequence and steps it on the same rising edge as the block. It compares every output on the following falling edge, which places each expected value in the one cycle it is due. On top of this, the words collected at the host and the memory contents written are checked against patterns computed from the requirements.

// File: rtl/aseq_pkg.sv
// Shared types for the auto-increment sequencer.
package aseq_pkg;
    // Sequencer phase: idle, waiting for host data, memory access in progress.
    typedef enum logic [1:0] {
        SQ_IDLE      = 2'd0,
        SQ_WAIT_DATA = 2'd1,
        SQ_ACCESS    = 2'd2
    } sq_state_t;
endpackage

// File: rtl/aseq_ctrl.sv
// Control FSM of the sequencer. It latches the mode at address load, gates
// the host data capture, waits for memory completion and samples the
// active-low auto-increment input in the completion cycle.
// Assumes: mem_done is only meaningful while an access is in progress.
module aseq_ctrl
    import aseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  logic      prog_i,
    input  logic      wvalid_i,
    input  logic      done_i,
    input  logic      ainc_n_i,
    output sq_state_t state_o,
    output logic      prog_o,
    output logic      ld_addr_o,
    output logic      step_addr_o,
    output logic      cap_wdata_o,
    output logic      cap_rdata_o
);
    sq_state_t state_q, state_d;
    logic      prog_q;
    logic      fin;

    // Decode the enables each datapath register needs in this cycle.
    always_comb begin
        fin         = (state_q == SQ_ACCESS) && done_i;
        ld_addr_o   = (state_q == SQ_IDLE) && load_i;
        cap_wdata_o = (state_q == SQ_WAIT_DATA) && wvalid_i;
        cap_rdata_o = fin && !prog_q;
        step_addr_o = fin && !ainc_n_i;
    end

    // Choose the next phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:      if (load_i)   state_d = prog_i ? SQ_WAIT_DATA : SQ_ACCESS;
            SQ_WAIT_DATA: if (wvalid_i) state_d = SQ_ACCESS;
            SQ_ACCESS: begin
                if (done_i) begin
                    if (!ainc_n_i) state_d = prog_q ? SQ_WAIT_DATA : SQ_ACCESS;
                    else           state_d = SQ_IDLE;
                end
            end
            default:                    state_d = SQ_IDLE;
        endcase
    end

    // Hold the phase and the mode latched at address load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            prog_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ld_addr_o) prog_q <= prog_i;
        end
    end

    assign state_o = state_q;
    assign prog_o  = prog_q;
endmodule

// File: rtl/aseq_addr_ctr.sv
// Word address register: loaded from the host, stepped by one on request,
// wrapping at the top of the AW-bit range.
// Assumes: load and step are never requested in the same cycle.
module aseq_addr_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] din_i,
    output logic [AW-1:0] q_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] q;

    // Load or advance the current word address.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load_i) q <= din_i;
        else if (step_i) q <= q + ONE;
    end

    assign q_o = q;
endmodule

// File: rtl/aseq_data_regs.sv
// Data holding registers: the host word to program, the dumped word for the
// host and its one-cycle valid pulse.
// Assumes: capture enables arrive already qualified by the FSM.
module aseq_data_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_w_i,
    input  logic [DW-1:0] host_w_i,
    input  logic          cap_r_i,
    input  logic [DW-1:0] mem_r_i,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);
    logic [DW-1:0] wdata_q, rdata_q;
    logic          rvalid_q;

    // Capture write and read words and raise the valid pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (cap_w_i) wdata_q <= host_w_i;
            if (cap_r_i) rdata_q <= mem_r_i;
            rvalid_q <= cap_r_i;
        end
    end

    assign wdata_o  = wdata_q;
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
endmodule

// File: rtl/aseq_top.sv
// Auto-increment slave programming sequencer. It takes one starting address
// and then programs or dumps consecutive words for as long as auto_inc_n is
// low at each completion.
// Assumes: the memory holds mem_done high for at least one cycle per access
// and keeps mem_rdata valid in that cycle.
module aseq_top
    import aseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_load,
    input  logic [AW-1:0] host_addr,
    input  logic          host_prog,
    input  logic          host_wvalid,
    input  logic [DW-1:0] host_wdata,
    output logic          host_rvalid,
    output logic [DW-1:0] host_rdata,
    input  logic          auto_inc_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_done,
    output logic          busy
);
    sq_state_t state;
    logic      prog, ld_addr, step_addr, cap_w, cap_r;

    aseq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (host_load),
        .prog_i     (host_prog),
        .wvalid_i   (host_wvalid),
        .done_i     (mem_done),
        .ainc_n_i   (auto_inc_n),
        .state_o    (state),
        .prog_o     (prog),
        .ld_addr_o  (ld_addr),
        .step_addr_o(step_addr),
        .cap_wdata_o(cap_w),
        .cap_rdata_o(cap_r)
    );

    aseq_addr_ctr #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(ld_addr),
        .step_i(step_addr),
        .din_i (host_addr),
        .q_o   (mem_addr)
    );

    aseq_data_regs #(.DW(DW)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_w_i (cap_w),
        .host_w_i(host_wdata),
        .cap_r_i (cap_r),
        .mem_r_i (mem_rdata),
        .wdata_o (mem_wdata),
        .rdata_o (host_rdata),
        .rvalid_o(host_rvalid)
    );

    // Strobes follow the registered phase, so they never depend on inputs.
    always_comb begin
        mem_wr = (state == SQ_ACCESS) && prog;
        mem_rd = (state == SQ_ACCESS) && !prog;
        busy   = (state != SQ_IDLE);
    end
endmodule

// File: rtl/aseq_checker.sv
// Protocol checker for aseq_top, attached by bind. Observes ports only.
module aseq_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic          mem_done,
    input logic [AW-1:0] mem_addr,
    input logic          auto_inc_n,
    input logic          host_rvalid
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_wr || mem_rd)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_wr || mem_rd) && !mem_done) |=> $stable(mem_addr)); // R3
    AST_RVALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(mem_rd && mem_done)); // R4
    AST_STEP_ON_AINC: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_wr || mem_rd) && mem_done && !auto_inc_n)
            |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R5
    AST_STOP_ON_NO_AINC: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_wr || mem_rd) && mem_done && auto_inc_n) |=> !busy); // R6
endmodule

bind aseq_top aseq_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_done   (mem_done),
    .mem_addr   (mem_addr),
    .auto_inc_n (auto_inc_n),
    .host_rvalid(host_rvalid)
);

// File: tb/aseq_top_tb_top.sv
// Bench: behavioural reference model compared every clock, memory responder
// with varying latency, and end-of-run content checks.
module aseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_load = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_prog = 1'b0;
    logic        host_wvalid = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        host_rvalid;
    logic [15:0] host_rdata;
    logic        auto_inc_n = 1'b1;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_wr, mem_rd, busy;
    logic [15:0] mem_rdata = '0;
    logic        mem_done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    aseq_top dut_i (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] pat(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    // Memory responder: latency from the address, done for one cycle,
    // auto_inc_n chosen from the number of words left in the run.
    logic [15:0] mem [int];
    int words_left = 0, lat_cnt = 0;
    always @(negedge clk) begin
        cyc++;
        host_wvalid <= (cyc % 3 == 1);
        host_wdata  <= 16'hC000 ^ 16'(cyc);
        if (mem_done) begin
            mem_done <= 1'b0;
            lat_cnt = 0;
        end else if (mem_wr || mem_rd) begin
            if (lat_cnt >= int'(mem_addr % 3)) begin
                mem_done <= 1'b1;
                if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : pat(mem_addr);
                if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
                auto_inc_n <= (words_left <= 1);
                words_left--;
            end else lat_cnt++;
        end else lat_cnt = 0;
    end

    // Reference model, stepped on the same edge as the design.
    int          m_st = 0;
    logic        m_prog = 0, m_rv = 0;
    logic [15:0] m_addr = 0, m_wd = 0, m_rd = 0;
    logic [15:0] exp_mem [int];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_prog = 0; m_rv = 0; m_addr = 0; m_wd = 0; m_rd = 0;
        end else begin
            m_rv = 0;
            if (m_st == 0) begin
                if (host_load) begin
                    m_addr = host_addr; m_prog = host_prog;
                    m_st = host_prog ? 1 : 2;
                end
            end else if (m_st == 1) begin
                if (host_wvalid) begin m_wd = host_wdata; m_st = 2; end
            end else if (mem_done) begin
                if (m_prog) exp_mem[int'(m_addr)] = m_wd;
                else begin m_rv = 1; m_rd = mem_rdata; end
                if (!auto_inc_n) begin
                    m_addr = m_addr + 16'd1;
                    m_st = m_prog ? 1 : 2;
                end else m_st = 0;
            end
        end
    end

    // Compare all outputs away from the edge; collect dumped words.
    logic [15:0] got [$];
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 busy in reset", busy, 0);
            chk("R1 strobes in reset", {mem_wr, mem_rd}, 0);
            chk("R1 rvalid in reset", host_rvalid, 0);
        end else begin
            chk("R2/R6 busy", busy, m_st != 0);
            chk("R3 mem_wr", mem_wr, m_st == 2 && m_prog);
            chk("R4 mem_rd", mem_rd, m_st == 2 && !m_prog);
            chk("R8 strobe exclusive", mem_wr && mem_rd, 0);
            if (m_st != 0) chk("R5/R7 mem_addr", mem_addr, m_addr);
            if (m_st == 2 && m_prog) chk("R3 mem_wdata", mem_wdata, m_wd);
            chk("R4 host_rvalid", host_rvalid, m_rv);
            if (m_rv) chk("R4 host_rdata", host_rdata, m_rd);
            if (host_rvalid) got.push_back(host_rdata);
        end
    end

    task automatic start(input logic [15:0] a, input logic prog, input int n);
        @(negedge clk);
        words_left = n;
        host_load <= 1'b1; host_addr <= a; host_prog <= prog;
        @(negedge clk);
        host_load <= 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n <= 1'b1;
        repeat (2) @(negedge clk);

        // Dump run of five words; a stray load mid-run must be ignored.
        got.delete();
        start(16'h0010, 1'b0, 5);
        repeat (3) @(negedge clk);
        host_load <= 1'b1; host_addr <= 16'h5555; host_prog <= 1'b1;
        @(negedge clk);
        host_load <= 1'b0;
        wait_idle();
        chk("R5 dumped word count", got.size(), 5);
        for (int i = 0; i < got.size(); i++)
            chk("R2/R4 dumped word", got[i], pat(16'h0010 + 16'(i)));

        // Program run of three words across the address wrap.
        start(16'hFFFE, 1'b1, 3);
        wait_idle();
        chk("R7 write at 0xFFFF", mem.exists(32'hFFFF), 1);
        chk("R7 write at 0x0000", mem.exists(0), 1);
        foreach (exp_mem[k]) chk("R3 programmed word", mem[k], exp_mem[k]);

        // Single word without auto-increment, then a dump of the wrapped word.
        start(16'h0200, 1'b1, 1);
        wait_idle();
        chk("R6 single write stored", mem.exists(32'h0200), 1);
        chk("R6 no second write", mem.exists(32'h0201), 0);
        got.delete();
        start(16'h0000, 1'b0, 1);
        wait_idle();
        chk("R6 single read count", got.size(), 1);
        if (got.size() == 1) chk("R7 wrapped word read back", got[0], exp_mem[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule